// File: doc/BRIEF.md
# Sized Integer Divider With Divide Fault

This block divides a double-width dividend by a single-width divisor at one of three operand sizes: a quarter, a half or the whole of the `MAX_W`-bit datapath, i.e. 8, 16 or 32 bits by default. The dividend is assembled from a high and a low input word in the way an accumulator/extension register pair is used. The quotient and the remainder are written back into a result image of that same pair. Bits of the pair that the chosen size does not touch are passed through unchanged. Division is unsigned, or signed in two's complement with truncation toward zero.

A `start_i` pulse latches the operands. One setup cycle checks the divisor and the upper half of the dividend. The block then produces one quotient bit per clock by restoring shift-subtract, and a final cycle applies the signs and the range check. If the divisor is zero or the quotient does not fit the operand size, `error_o` rises together with `done_o` and the result outputs keep their previous values.

Top module: `sized_div`

## Requirements
- R1: After reset `res_hi_o`, `res_lo_o` are zero and `done_o`, `error_o` are low.
- R2: Byte size (`size_i`=2'b00, N=8): the dividend is `dvd_lo_i[15:0]`; the quotient goes to `res_lo_o[7:0]` and the remainder to `res_lo_o[15:8]`; `res_lo_o[31:16]` copies `dvd_lo_i[31:16]` and `res_hi_o` copies `dvd_hi_i`.
- R3: Word size (`size_i`=2'b01, N=16): the dividend is `{dvd_hi_i[15:0], dvd_lo_i[15:0]}`; the quotient goes to `res_lo_o[15:0]` and the remainder to `res_hi_o[15:0]`; the upper 16 bits of each output copy the matching input.
- R4: Long size (`size_i`=2'b10 or 2'b11, N=32): the dividend is `{dvd_hi_i, dvd_lo_i}`; the quotient is `res_lo_o` and the remainder is `res_hi_o`.
- R5: With `signed_i`=0 the operands are unsigned and the results satisfy dividend = quotient*divisor + remainder with remainder < divisor. The divisor is `dvs_i[N-1:0]`.
- R6: With `signed_i`=1 the operands are two's complement. The quotient truncates toward zero and the remainder carries the dividend's sign (-211 / 4 gives quotient -52, remainder -3).
- R7: A zero divisor raises `error_o` in the same cycle as `done_o`, and the result outputs are not changed.
- R8: A quotient outside the N-bit range raises `error_o` with `done_o` and leaves the outputs unchanged. The unsigned range is below 2^N; the signed range is -2^(N-1) to 2^(N-1)-1, and the most negative N-bit dividend divided by -1 falls outside it.
- R9: Latency is counted from the clock edge that samples `start_i`. A zero divisor, or an upper dividend-magnitude half not below the divisor magnitude, reports `done_o` at the next edge. Every other operation, signed range faults included, reports `done_o` N+2 edges after.
- R10: `done_o` is a one-cycle pulse. A `start_i` seen while an operation is in progress is ignored and does not disturb that operation's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division (sampled when idle) |
| size_i | input | 2 | Operand size: 00 byte, 01 word, 10/11 long |
| signed_i | input | 1 | 1 selects signed division |
| dvd_hi_i | input | MAX_W | High (extension) register of the dividend pair |
| dvd_lo_i | input | MAX_W | Low (accumulator) register of the dividend pair |
| dvs_i | input | MAX_W | Divisor, low N bits used |
| res_hi_o | output | MAX_W | Result image of the high register |
| res_lo_o | output | MAX_W | Result image of the low register |
| done_o | output | 1 | Operation finished, one-cycle pulse |
| error_o | output | 1 | Divide fault, asserted with done_o |

## Verification
The byte size is swept over a regular grid of 16-bit dividends against a fixed divisor set. That set holds zero, one, small values, a power of two and all-ones, and the grid is run in both signed and unsigned form. This separates sign handling, the upper-half precheck and the signed range fault from plain quotient bits. Word and long sizes are driven with pseudo-random operands in which the high half is either random or a pure sign extension. The first kind mostly overflows and the second mostly fits, so both the early fault path and the full N-step path run at sizes where bit placement and pass-through bits differ. Fixed vectors then pin truncation toward zero, the most-negative-by-minus-one case, the alternate long size code, a start issued while busy and the single-cycle done pulse.

// File: rtl/sized_div_pkg.sv
package sized_div_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_LALT = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RUN,
    ST_FIX
  } state_e;
endpackage

// File: rtl/sized_div_unpack.sv
module sized_div_unpack
  import sized_div_pkg::*;
#(
  parameter int unsigned MAX_W = 32
) (
  input  size_e            size_i,
  input  logic             signed_i,
  input  logic [MAX_W-1:0] hi_i,
  input  logic [MAX_W-1:0] lo_i,
  input  logic [MAX_W-1:0] dvs_i,
  output logic [MAX_W-1:0] rem_init_o,
  output logic [MAX_W-1:0] quo_init_o,
  output logic [MAX_W-1:0] dvs_mag_o,
  output logic             dvd_neg_o,
  output logic             dvs_neg_o
);
  localparam int unsigned HW = MAX_W / 2;
  localparam int unsigned QW = MAX_W / 4;
  localparam int unsigned DW = 2 * MAX_W;

  logic [DW-1:0]    dvd_ext, dvd_mag;
  logic [MAX_W-1:0] dvs_ext;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        dvd_ext = {{(DW-HW){signed_i & lo_i[HW-1]}}, lo_i[HW-1:0]};
        dvs_ext = {{(MAX_W-QW){signed_i & dvs_i[QW-1]}}, dvs_i[QW-1:0]};
      end
      SZ_WORD: begin
        dvd_ext = {{MAX_W{signed_i & hi_i[HW-1]}}, hi_i[HW-1:0], lo_i[HW-1:0]};
        dvs_ext = {{(MAX_W-HW){signed_i & dvs_i[HW-1]}}, dvs_i[HW-1:0]};
      end
      default: begin
        dvd_ext = {hi_i, lo_i};
        dvs_ext = dvs_i;
      end
    endcase
    dvd_neg_o = signed_i & dvd_ext[DW-1];
    dvs_neg_o = signed_i & dvs_ext[MAX_W-1];
    dvd_mag   = dvd_neg_o ? -dvd_ext : dvd_ext;
    dvs_mag_o = dvs_neg_o ? -dvs_ext : dvs_ext;
    // upper half seeds the partial remainder, lower half is left-aligned for shifting
    unique case (size_i)
      SZ_BYTE: begin
        rem_init_o = MAX_W'(dvd_mag >> QW);
        quo_init_o = {dvd_mag[QW-1:0], {(MAX_W-QW){1'b0}}};
      end
      SZ_WORD: begin
        rem_init_o = MAX_W'(dvd_mag >> HW);
        quo_init_o = {dvd_mag[HW-1:0], {(MAX_W-HW){1'b0}}};
      end
      default: begin
        rem_init_o = dvd_mag[DW-1:MAX_W];
        quo_init_o = dvd_mag[MAX_W-1:0];
      end
    endcase
  end
endmodule

// File: rtl/sized_div_core.sv
module sized_div_core #(
  parameter int unsigned MAX_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [MAX_W-1:0] rem_init_i,
  input  logic [MAX_W-1:0] quo_init_i,
  input  logic [MAX_W-1:0] dvs_i,
  output logic [MAX_W-1:0] rem_o,
  output logic [MAX_W-1:0] quo_o
);
  logic [MAX_W:0]   trial;
  logic [MAX_W-1:0] diff;
  logic             fits;

  always_comb begin
    trial = {rem_o, quo_o[MAX_W-1]};
    fits  = trial >= {1'b0, dvs_i};
    diff  = MAX_W'(trial - {1'b0, dvs_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_o <= '0;
      quo_o <= '0;
    end else if (load_i) begin
      rem_o <= rem_init_i;
      quo_o <= quo_init_i;
    end else if (step_i) begin
      rem_o <= fits ? diff : trial[MAX_W-1:0];
      quo_o <= {quo_o[MAX_W-2:0], fits};
    end
  end

  // partial remainder stays below the divisor once the precheck has passed
  assert_rem_below_dvs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (rem_o < dvs_i));
endmodule

// File: rtl/sized_div_pack.sv
module sized_div_pack
  import sized_div_pkg::*;
#(
  parameter int unsigned MAX_W = 32
) (
  input  size_e            size_i,
  input  logic             signed_i,
  input  logic             dvd_neg_i,
  input  logic             dvs_neg_i,
  input  logic [MAX_W-1:0] rem_i,
  input  logic [MAX_W-1:0] quo_i,
  input  logic [MAX_W-1:0] hi_i,
  input  logic [MAX_W-1:0] lo_i,
  output logic [MAX_W-1:0] hi_o,
  output logic [MAX_W-1:0] lo_o,
  output logic             ovf_o
);
  localparam int unsigned HW = MAX_W / 2;
  localparam int unsigned QW = MAX_W / 4;

  logic [MAX_W-1:0] mask, q_mag, q_val, r_val, lim_pos;
  logic             q_neg, r_neg;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: mask = {{(MAX_W-QW){1'b0}}, {QW{1'b1}}};
      SZ_WORD: mask = {{(MAX_W-HW){1'b0}}, {HW{1'b1}}};
      default: mask = '1;
    endcase
    lim_pos = mask >> 1;
    q_mag   = quo_i & mask;
    q_neg   = signed_i & (dvd_neg_i ^ dvs_neg_i);
    r_neg   = signed_i & dvd_neg_i;
    // negative side of the range holds one more magnitude
    ovf_o   = signed_i & (q_neg ? (q_mag > lim_pos + 1'b1) : (q_mag > lim_pos));
    q_val   = (q_neg ? -q_mag : q_mag) & mask;
    r_val   = (r_neg ? -rem_i : rem_i) & mask;
    unique case (size_i)
      SZ_BYTE: begin
        lo_o = {lo_i[MAX_W-1:HW], r_val[QW-1:0], q_val[QW-1:0]};
        hi_o = hi_i;
      end
      SZ_WORD: begin
        lo_o = {lo_i[MAX_W-1:HW], q_val[HW-1:0]};
        hi_o = {hi_i[MAX_W-1:HW], r_val[HW-1:0]};
      end
      default: begin
        lo_o = q_val;
        hi_o = r_val;
      end
    endcase
  end
endmodule

// File: rtl/sized_div.sv
module sized_div
  import sized_div_pkg::*;
#(
  parameter int unsigned MAX_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       size_i,
  input  logic             signed_i,
  input  logic [MAX_W-1:0] dvd_hi_i,
  input  logic [MAX_W-1:0] dvd_lo_i,
  input  logic [MAX_W-1:0] dvs_i,
  output logic [MAX_W-1:0] res_hi_o,
  output logic [MAX_W-1:0] res_lo_o,
  output logic             done_o,
  output logic             error_o
);
  localparam int unsigned CW = $clog2(MAX_W);
  localparam int unsigned HW = MAX_W / 2;
  localparam int unsigned QW = MAX_W / 4;

  state_e           state_q;
  size_e            size_q;
  logic             sgn_q, dvd_neg_q, dvs_neg_q;
  logic [MAX_W-1:0] dvs_q, hi_q, lo_q;
  logic [CW-1:0]    cnt_q;

  logic [MAX_W-1:0] rem_init, quo_init, dvs_mag, rem, quo, pack_hi, pack_lo;
  logic             dvd_neg, dvs_neg, ovf, accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  function automatic logic [CW-1:0] last_step(input size_e s);
    unique case (s)
      SZ_BYTE: last_step = CW'(QW - 1);
      SZ_WORD: last_step = CW'(HW - 1);
      default: last_step = CW'(MAX_W - 1);
    endcase
  endfunction

  sized_div_unpack #(.MAX_W(MAX_W)) i_unpack (
    .size_i    (size_e'(size_i)),
    .signed_i  (signed_i),
    .hi_i      (dvd_hi_i),
    .lo_i      (dvd_lo_i),
    .dvs_i     (dvs_i),
    .rem_init_o(rem_init),
    .quo_init_o(quo_init),
    .dvs_mag_o (dvs_mag),
    .dvd_neg_o (dvd_neg),
    .dvs_neg_o (dvs_neg)
  );

  sized_div_core #(.MAX_W(MAX_W)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .step_i    (state_q == ST_RUN),
    .rem_init_i(rem_init),
    .quo_init_i(quo_init),
    .dvs_i     (dvs_q),
    .rem_o     (rem),
    .quo_o     (quo)
  );

  sized_div_pack #(.MAX_W(MAX_W)) i_pack (
    .size_i   (size_q),
    .signed_i (sgn_q),
    .dvd_neg_i(dvd_neg_q),
    .dvs_neg_i(dvs_neg_q),
    .rem_i    (rem),
    .quo_i    (quo),
    .hi_i     (hi_q),
    .lo_i     (lo_q),
    .hi_o     (pack_hi),
    .lo_o     (pack_lo),
    .ovf_o    (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      size_q    <= SZ_BYTE;
      sgn_q     <= 1'b0;
      dvd_neg_q <= 1'b0;
      dvs_neg_q <= 1'b0;
      dvs_q     <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      cnt_q     <= '0;
      res_hi_o  <= '0;
      res_lo_o  <= '0;
      done_o    <= 1'b0;
      error_o   <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      error_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_CHECK;
          size_q    <= size_e'(size_i);
          sgn_q     <= signed_i;
          dvd_neg_q <= dvd_neg;
          dvs_neg_q <= dvs_neg;
          dvs_q     <= dvs_mag;
          hi_q      <= dvd_hi_i;
          lo_q      <= dvd_lo_i;
        end
        ST_CHECK: begin
          // zero divisor or upper half >= divisor: quotient cannot fit
          if (dvs_q == '0 || rem >= dvs_q) begin
            done_o  <= 1'b1;
            error_o <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q   <= last_step(size_q);
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cnt_q == '0) state_q <= ST_FIX;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_FIX: begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
          if (ovf) begin
            error_o <= 1'b1;
          end else begin
            res_hi_o <= pack_hi;
            res_lo_o <= pack_lo;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_err_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  assert_err_holds_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> ($stable(res_hi_o) && $stable(res_lo_o)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_holds_operands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=> ($stable(dvs_q) && $stable(size_q) && $stable(sgn_q)));
endmodule

// File: tb/test_sized_div.sv
module test_sized_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  size = 2'b00;
  logic        sgn = 1'b0;
  logic [31:0] dhi = '0, dlo = '0, dvs = '0;
  logic [31:0] rhi, rlo;
  logic        done, err;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  sized_div i_sized_div (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .signed_i(sgn),
    .dvd_hi_i(dhi), .dvd_lo_i(dlo), .dvs_i(dvs),
    .res_hi_o(rhi), .res_lo_o(rlo), .done_o(done), .error_o(err)
  );

  function automatic logic [31:0] rnd_next(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // drives one operation and compares against values derived from R2..R9
  task automatic do_op(input logic [1:0] sz, input logic sg, input logic [31:0] hi,
                       input logic [31:0] lo, input logic [31:0] dv, input string req);
    int          n, lat, exp_lat;
    logic [63:0] mask_n, mask_2n, dvd_u, dvs_u, ma, mb, qm, rm, qv, rv;
    logic        dn, vn, qn, rn, fault, pre;
    logic [31:0] ehi, elo, phi, plo;
    n       = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    mask_n  = (64'd1 << n) - 1;
    mask_2n = (n == 32) ? '1 : ((64'd1 << (2 * n)) - 1);
    case (sz)
      2'b00:   dvd_u = {48'd0, lo[15:0]};
      2'b01:   dvd_u = {32'd0, hi[15:0], lo[15:0]};
      default: dvd_u = {hi, lo};
    endcase
    dvs_u = {32'd0, dv} & mask_n;
    dn = sg && dvd_u[2*n-1];
    vn = sg && dvs_u[n-1];
    ma = dn ? ((~dvd_u + 1) & mask_2n) : dvd_u;
    mb = vn ? ((~dvs_u + 1) & mask_n) : dvs_u;
    qm = (mb == 0) ? 0 : ma / mb;
    rm = (mb == 0) ? 0 : ma % mb;
    qn = sg && (dn ^ vn);
    rn = dn;
    pre   = (mb == 0) || ((ma >> n) >= mb);
    fault = (mb == 0) ||
            (!sg && qm > mask_n) ||
            (sg && (qn ? (qm > (64'd1 << (n - 1))) : (qm > ((64'd1 << (n - 1)) - 1))));
    qv = qn ? ((~qm + 1) & mask_n) : qm;
    rv = rn ? ((~rm + 1) & mask_n) : rm;
    phi = rhi;
    plo = rlo;
    if (fault) begin
      ehi = phi;
      elo = plo;
    end else begin
      case (sz)
        2'b00:   begin elo = {lo[31:16], rv[7:0], qv[7:0]}; ehi = hi; end
        2'b01:   begin elo = {lo[31:16], qv[15:0]}; ehi = {hi[31:16], rv[15:0]}; end
        default: begin elo = qv[31:0]; ehi = rv[31:0]; end
      endcase
    end
    exp_lat = pre ? 1 : n + 2;
    size = sz; sgn = sg; dhi = hi; dlo = lo; dvs = dv; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat = 0;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk);
      #1 lat++;
      if (done) break;
    end
    check(done && (lat == exp_lat) && (err == fault) && (rhi == ehi) && (rlo == elo),
          (fault ? (pre && mb == 0 ? "R7" : "R8") : req),
          $sformatf("sz=%0d sg=%0d hi=%h lo=%h dv=%h lat/err/hi/lo", sz, sg, hi, lo, dv),
          {32'(lat), 31'd0, err, rhi, rlo}, {32'(exp_lat), 31'd0, fault, ehi, elo});
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #7 rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R1: reset state
    check(rhi == 0 && rlo == 0 && !done && !err, "R1", "reset outputs",
          {rhi, rlo, 62'd0, done, err}, 128'd0);

    // R2 R5: 0x0333 / 4 unsigned byte -> q=204 r=3
    do_op(2'b00, 1'b0, 32'hAAAA_5555, 32'h1234_0333, 32'h0000_0004, "R2");
    check(rlo == 32'h1234_03CC && rhi == 32'hAAAA_5555, "R2", "byte unsigned literal",
          {rhi, rlo}, {32'hAAAA_5555, 32'h1234_03CC});
    // R6: -211 / 4 signed byte -> q=-52 (CC) r=-3 (FD)
    do_op(2'b00, 1'b1, 32'h0, 32'h0000_FF2D, 32'h0000_0004, "R6");
    check(rlo[15:0] == 16'hFDCC, "R6", "byte signed truncation", rlo, 32'h0000_FDCC);
    // R3 R6: word signed -52435 / 4
    do_op(2'b01, 1'b1, 32'h0000_FFFF, 32'h0000_332D, 32'h0000_0004, "R3");
    check(rhi == 32'h0000_FFFD && rlo == 32'h0000_CCCC, "R3", "word signed literal",
          {rhi, rlo}, {32'h0000_FFFD, 32'h0000_CCCC});
    // R4: long signed
    do_op(2'b10, 1'b1, 32'hFFFF_FFFF, 32'h3333_332D, 32'h0000_0004, "R4");
    check(rhi == 32'hFFFF_FFFD && rlo == 32'hCCCC_CCCC, "R4", "long signed literal",
          {rhi, rlo}, {32'hFFFF_FFFD, 32'hCCCC_CCCC});
    // R4: alternate long code 2'b11, unsigned
    do_op(2'b11, 1'b0, 32'h0000_0003, 32'h3333_3333, 32'h0000_0004, "R4");
    check(rhi == 32'h3 && rlo == 32'hCCCC_CCCC, "R4", "size code 11 as long",
          {rhi, rlo}, {32'h3, 32'hCCCC_CCCC});
    // R7: zero divisor keeps previous result
    do_op(2'b01, 1'b0, 32'h1, 32'h2, 32'hFFFF_0000, "R7");
    check(rhi == 32'h3 && rlo == 32'hCCCC_CCCC, "R7", "zero divisor holds outputs",
          {rhi, rlo}, {32'h3, 32'hCCCC_CCCC});
    // R8: most negative byte dividend / -1, faults late (R9 latency 10)
    do_op(2'b00, 1'b1, 32'h0, 32'h0000_FF80, 32'h0000_00FF, "R8");
    check(rhi == 32'h3 && rlo == 32'hCCCC_CCCC, "R8", "min/-1 holds outputs",
          {rhi, rlo}, {32'h3, 32'hCCCC_CCCC});
    // R8 R9: unsigned overflow detected at precheck
    do_op(2'b10, 1'b0, 32'h0000_0010, 32'h0, 32'h0000_0010, "R9");

    // R10: done is one cycle
    do_op(2'b00, 1'b0, 32'h0, 32'h0000_0064, 32'h0000_0007, "R10");
    @(posedge clk);
    #1 check(!done, "R10", "done pulse width", {127'd0, done}, 128'd0);

    // R10: start while busy is ignored
    begin
      int seen;
      size = 2'b10; sgn = 1'b0; dhi = 32'h0; dlo = 32'd1000; dvs = 32'd7; start = 1'b1;
      @(posedge clk);
      #1 dlo = 32'd5; dvs = 32'd2; size = 2'b00;
      seen = 0;
      for (int k = 0; k < 60; k++) begin
        @(posedge clk);
        #1 if (done) seen++;
        if (k == 20) start = 1'b0;
      end
      start = 1'b0;
      check(seen == 1 && rlo == 32'd142 && rhi == 32'd6, "R10", "start while busy",
            {32'(seen), rhi, rlo}, {32'd1, 32'd6, 32'd142});
    end

    // byte grid, both signedness
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 65536; d += 251) begin
        for (int j = 0; j < 8; j++) begin
          logic [31:0] dv;
          case (j)
            0: dv = 32'h0;   1: dv = 32'h1;   2: dv = 32'h2;   3: dv = 32'h3;
            4: dv = 32'h4;   5: dv = 32'h7;   6: dv = 32'h64;  default: dv = 32'hFF;
          endcase
          do_op(2'b00, s[0], 32'h5A5A_A5A5, {16'hC3C3, d[15:0]}, {24'hABCDEF, dv[7:0]},
                s[0] ? "R6" : "R5");
        end
      end
    end

    // word and long pseudo-random
    for (int k = 0; k < 600; k++) begin
      logic [31:0] a, b, c, hi;
      seed = rnd_next(seed); a = seed;
      seed = rnd_next(seed); b = seed;
      seed = rnd_next(seed); c = seed;
      if (k % 3 == 0) c = c & 32'h0000_000F;
      if (k < 300) begin
        hi = (k % 2 == 1) ? a : {a[31:16], {16{a[7]}}};
        do_op(2'b01, k[2], hi, b, c, "R3");
      end else begin
        hi = (k % 2 == 1) ? a : {32{a[7]}};
        do_op(2'b10, k[2], hi, b, c, "R4");
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule